// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Return-Address Stack

The block gathers four interrupt sources: a falling edge on an external pin, a timer overflow pulse, a conversion-done pulse and a serial-bus event pulse. Each source latches a request flag. A flag stays set until its interrupt is taken or software clears it. Each source has its own enable bit, and a master enable gates all four. Two byte-wide control registers are read and written through a simple select/write port. On an acknowledge the block produces a fixed entry vector for the winning source, clears that source's flag and clears the master enable.

The same block keeps a six-level return-address stack. A subroutine call or an acknowledge pushes the program counter, and a return or return-from-interrupt pops it. The address that the next return will restore is always visible on `pop_addr`. While all six levels are in use, no acknowledge is granted. The request stays recorded and is served once a return frees a level. A call made on a full stack discards the oldest entry.

The acknowledge decision is taken by a small state machine with two states. ST_IDLE waits for a sample strobe. The transition IDLE_TO_GRANT fires when the strobe finds an enabled request, the stack has room and no call or return strobe is present in that cycle. ST_GRANT holds `ack_o` high for exactly one cycle with the vector. The transition GRANT_TO_IDLE is unconditional. Instruction decode lies outside the block.

Top module: `irq_stack_ctrl`

## Requirements
- R1: When several enabled requests are pending at an acknowledge, the external source wins, then the timer, then conversion-done, then serial. The vectors are 0x004, 0x008, 0x00C and 0x010 respectively.
- R2: The external flag is set by a high-to-low transition of `ext_pin`. Neither a rising edge nor a held low level sets it again.
- R3: A request flag stays set until its interrupt is acknowledged or software writes it. Software may also write a flag to 1. A pulse on `tmr_evt`, `cnv_evt` or `ser_evt` sets its flag, and a hardware set wins over a same-cycle write or clear.
- R4: An acknowledge clears the granted source's flag and the master enable, and leaves the other flags unchanged. While the master enable is 0, no further acknowledge occurs.
- R5: `reti_stb` sets the master enable in addition to popping the stack. `ret_stb` pops the stack and leaves the master enable unchanged.
- R6: A source is acknowledged only when its flag, its own enable and the master enable are all 1.
- R7: While the stack holds 6 entries, no acknowledge is granted and the flag stays recorded. After a return pops a level, the next sample grants the request.
- R8: A call on a full stack drops the oldest entry, so that only the 6 most recent addresses are kept. Pops return addresses in last-in first-out order, and `pop_addr` shows the top entry.
- R9: Register layout, selected by `reg_sel`. Byte 0 (reg_sel=0) holds the master enable in bit 0, the external, timer and conversion enables in bits 1 to 3, the external, timer and conversion flags in bits 4 to 6, and bit 7 reads 0. Byte 1 (reg_sel=1) holds the serial enable in bit 0 and the serial flag in bit 4, and its other bits read 0.
- R10: After reset, both control bytes read 0x00, the stack is empty and `ack_o` is 0.
- R11: An acknowledge is decided only in a cycle with `sample_stb` high and no call, return or return-from-interrupt strobe. The decision pushes `pc_in` and raises `ack_o` with `vector_o` for the following single cycle. During that cycle a sample is ignored. If a call and a return arrive together, the call pushes and the return is ignored.
- R12: A return on an empty stack leaves the stack empty, so that six later calls are all kept and pop back in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 1 | External interrupt pin, falling-edge sensitive |
| tmr_evt | input | 1 | Timer overflow pulse |
| cnv_evt | input | 1 | Conversion-done pulse |
| ser_evt | input | 1 | Serial-bus event pulse |
| reg_wr | input | 1 | Write strobe for the selected control byte |
| reg_sel | input | 1 | Control byte select (0 or 1) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected control byte |
| call_stb | input | 1 | Subroutine call: push `pc_in` |
| ret_stb | input | 1 | Plain return: pop |
| reti_stb | input | 1 | Return from interrupt: pop and set master enable |
| sample_stb | input | 1 | Once-per-instruction acknowledge evaluation strobe |
| pc_in | input | 11 | Program counter to push |
| ack_o | output | 1 | One-cycle acknowledge pulse |
| vector_o | output | 11 | Entry vector, valid while `ack_o` is high |
| pop_addr | output | 11 | Top-of-stack address that a return restores |

## Verification
All four flags are raised together with every enable on, which shows that the priority order and each vector are correct. Acknowledges are then repeated with the master enable dropped and restored by either return, which separates return-from-interrupt from plain return. Enable combinations with a single bit off show that every gate is needed. The stack is filled, overfilled and popped while empty; this separates withholding from dropping the oldest entry and catches pointer underflow. Long stretches of seeded random traffic on all inputs are compared cycle by cycle against a bench model of flags, enables and stack. These runs expose precedence mistakes between writes, hardware sets, acknowledges and returns arriving in the same cycle.

// File: rtl/irq_stack_pkg.sv
package irq_stack_pkg;

    // number of request sources; the register layout fixes this at four
    localparam int NSRC  = 4;
    localparam int SRC_W = $clog2(NSRC);

    // source indices in priority order (lowest index wins)
    localparam int SRC_EXT = 0;
    localparam int SRC_TMR = 1;
    localparam int SRC_CNV = 2;
    localparam int SRC_SER = 3;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_GRANT = 1'b1
    } arb_state_t;

endpackage

// File: rtl/irq_flags.sv
module irq_flags
    import irq_stack_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_pin,
    input  logic             tmr_evt,
    input  logic             cnv_evt,
    input  logic             ser_evt,
    input  logic             wr_en,
    input  logic             sel,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data,
    input  logic             reti_set,
    input  logic             grant,
    input  logic [SRC_W-1:0] grant_src,
    output logic [NSRC-1:0]  pend,
    output logic             emi_q
);

    logic            ext_prev_q;
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] flg_q;
    logic [NSRC-1:0] hw_set;
    logic            emi_d;

    // falling edge detector for the external pin
    always_ff @(posedge clk) begin
        if (!rst_n) ext_prev_q <= 1'b1;
        else        ext_prev_q <= ext_pin;
    end

    assign hw_set[SRC_EXT] = ext_prev_q & ~ext_pin;
    assign hw_set[SRC_TMR] = tmr_evt;
    assign hw_set[SRC_CNV] = cnv_evt;
    assign hw_set[SRC_SER] = ser_evt;

    // master enable: write, then return-from-interrupt, then acknowledge
    always_comb begin
        emi_d = emi_q;
        if (wr_en && !sel) emi_d = wr_data[0];
        if (reti_set)      emi_d = 1'b1;
        if (grant)         emi_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) emi_q <= 1'b0;
        else        emi_q <= emi_d;
    end

    // per-source enable and flag bits
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        localparam bit IN_B1  = (g == SRC_SER);
        localparam int EN_BIT = IN_B1 ? 0 : (1 + g);
        localparam int FL_BIT = IN_B1 ? 4 : (4 + g);

        logic wr_hit;
        logic en_d;
        logic fl_d;

        assign wr_hit = wr_en && (sel == IN_B1);

        always_comb begin
            en_d = en_q[g];
            fl_d = flg_q[g];
            if (wr_hit) begin
                en_d = wr_data[EN_BIT];
                fl_d = wr_data[FL_BIT];
            end
            if (grant && (grant_src == SRC_W'(g))) fl_d = 1'b0;
            if (hw_set[g])                           fl_d = 1'b1;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[g]  <= 1'b0;
                flg_q[g] <= 1'b0;
            end else begin
                en_q[g]  <= en_d;
                flg_q[g] <= fl_d;
            end
        end
    end

    assign pend = flg_q & en_q & {NSRC{emi_q}};

    always_comb begin
        if (!sel) begin
            rd_data = {1'b0, flg_q[SRC_CNV], flg_q[SRC_TMR], flg_q[SRC_EXT],
                       en_q[SRC_CNV], en_q[SRC_TMR], en_q[SRC_EXT], emi_q};
        end else begin
            rd_data = {3'b000, flg_q[SRC_SER], 3'b000, en_q[SRC_SER]};
        end
    end

endmodule

// File: rtl/irq_ret_stack.sv
module irq_ret_stack #(
    parameter int PC_W  = 11,
    parameter int DEPTH = 6,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [PC_W-1:0]  push_data,
    input  logic             pop,
    output logic [PC_W-1:0]  top_data,
    output logic [CNT_W-1:0] cnt,
    output logic             full
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PC_W-1:0]  mem_q [DEPTH];
    logic [PTR_W-1:0] wptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PTR_W-1:0] top_idx;

    assign top_idx  = (wptr_q == '0) ? LAST : wptr_q - 1'b1;
    assign top_data = mem_q[top_idx];
    assign cnt      = cnt_q;
    assign full     = (cnt_q == CNT_W'(DEPTH));

    // circular store: a push on a full stack overwrites the oldest slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            cnt_q  <= '0;
        end else if (push) begin
            wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
            if (!full) cnt_q <= cnt_q + 1'b1;
        end else if (pop && (cnt_q != '0)) begin
            wptr_q <= top_idx;
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[wptr_q] <= push_data;
    end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_stack_pkg::*;
#(
    parameter int PC_W     = 11,
    parameter int VEC_STEP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  pend,
    input  logic             sample_stb,
    input  logic             blocked,
    input  logic             stk_full,
    output logic             grant,
    output logic [SRC_W-1:0] grant_src,
    output logic             ack_o,
    output logic [PC_W-1:0]  vector_o
);

    arb_state_t      state_q, state_d;
    logic [PC_W-1:0] vec_q;

    // fixed priority: lowest index wins
    always_comb begin
        grant_src = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) grant_src = SRC_W'(i);
        end
    end

    assign grant = (state_q == ST_IDLE) && sample_stb && !blocked &&
                   (|pend) && !stk_full;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (grant) state_d = ST_GRANT;
            ST_GRANT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     vec_q <= '0;
        else if (grant) vec_q <= PC_W'((int'(grant_src) + 1) * VEC_STEP);
    end

    always_comb begin
        ack_o    = 1'b0;
        vector_o = vec_q;
        unique case (state_q)
            ST_IDLE:  ack_o = 1'b0;
            ST_GRANT: ack_o = 1'b1;
            default:  ack_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_stack_ctrl.sv
module irq_stack_ctrl
    import irq_stack_pkg::*;
#(
    parameter int PC_W     = 11,
    parameter int DEPTH    = 6,
    parameter int VEC_STEP = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext_pin,
    input  logic            tmr_evt,
    input  logic            cnv_evt,
    input  logic            ser_evt,
    input  logic            reg_wr,
    input  logic            reg_sel,
    input  logic [7:0]      reg_wdata,
    output logic [7:0]      reg_rdata,
    input  logic            call_stb,
    input  logic            ret_stb,
    input  logic            reti_stb,
    input  logic            sample_stb,
    input  logic [PC_W-1:0] pc_in,
    output logic            ack_o,
    output logic [PC_W-1:0] vector_o,
    output logic [PC_W-1:0] pop_addr
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [NSRC-1:0]  pend;
    logic             emi_q;
    logic             grant;
    logic [SRC_W-1:0] grant_src;
    logic             blocked;
    logic             stk_full;
    logic [CNT_W-1:0] stk_cnt;
    logic             push;
    logic             pop;

    assign blocked = call_stb | ret_stb | reti_stb;
    assign push    = call_stb | grant;
    assign pop     = (ret_stb | reti_stb) & ~call_stb;

    irq_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_pin   (ext_pin),
        .tmr_evt   (tmr_evt),
        .cnv_evt   (cnv_evt),
        .ser_evt   (ser_evt),
        .wr_en     (reg_wr),
        .sel       (reg_sel),
        .wr_data   (reg_wdata),
        .rd_data   (reg_rdata),
        .reti_set  (reti_stb),
        .grant     (grant),
        .grant_src (grant_src),
        .pend      (pend),
        .emi_q     (emi_q)
    );

    irq_arbiter #(
        .PC_W     (PC_W),
        .VEC_STEP (VEC_STEP)
    ) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend       (pend),
        .sample_stb (sample_stb),
        .blocked    (blocked),
        .stk_full   (stk_full),
        .grant      (grant),
        .grant_src  (grant_src),
        .ack_o      (ack_o),
        .vector_o   (vector_o)
    );

    irq_ret_stack #(
        .PC_W  (PC_W),
        .DEPTH (DEPTH)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (pc_in),
        .pop       (pop),
        .top_data  (pop_addr),
        .cnt       (stk_cnt),
        .full      (stk_full)
    );

endmodule

// File: rtl/irq_stack_ctrl_checker.sv
module irq_stack_ctrl_checker #(
    parameter int PC_W  = 11,
    parameter int DEPTH = 6,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sample_stb,
    input logic             call_stb,
    input logic             ret_stb,
    input logic             reti_stb,
    input logic             ack_o,
    input logic [PC_W-1:0]  vector_o,
    input logic [CNT_W-1:0] stk_cnt,
    input logic             emi_q
);

    assert_vector_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (vector_o == PC_W'(4) || vector_o == PC_W'(8) ||
                   vector_o == PC_W'(12) || vector_o == PC_W'(16)));

    assert_ack_clears_master_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> !emi_q);

    assert_reti_sets_master_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reti_stb |=> emi_q);

    assert_ack_needs_room_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (int'($past(stk_cnt)) < DEPTH));

    assert_full_call_keeps_depth_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (call_stb && int'(stk_cnt) == DEPTH) |=> (int'(stk_cnt) == DEPTH));

    assert_ack_after_clean_sample_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> ($past(sample_stb) && !$past(call_stb || ret_stb || reti_stb)));

    assert_single_cycle_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

    assert_empty_pop_stays_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_stb && !call_stb && stk_cnt == '0) |=> (stk_cnt == '0));

endmodule

bind irq_stack_ctrl irq_stack_ctrl_checker #(
    .PC_W  (PC_W),
    .DEPTH (DEPTH)
) u_chk (.*);

// File: tb/irq_stack_ctrl_test.sv
`timescale 1ns/1ps
module irq_stack_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_pin = 1'b1;
    logic        tmr_evt = 1'b0, cnv_evt = 1'b0, ser_evt = 1'b0;
    logic        reg_wr = 1'b0, reg_sel = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        call_stb = 1'b0, ret_stb = 1'b0, reti_stb = 1'b0, sample_stb = 1'b0;
    logic [10:0] pc_in = '0;
    logic        ack_o;
    logic [10:0] vector_o;
    logic [10:0] pop_addr;

    int checks = 0;
    int errors = 0;

    // bench model
    bit       m_emi;
    bit [3:0] m_en, m_flg;
    int       stk[6];
    int       scnt;
    bit       m_ack;
    int       m_vec;
    bit       m_prev;

    always #2.5 clk = ~clk;

    irq_stack_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr_evt(tmr_evt),
        .cnv_evt(cnv_evt), .ser_evt(ser_evt), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .call_stb(call_stb),
        .ret_stb(ret_stb), .reti_stb(reti_stb), .sample_stb(sample_stb),
        .pc_in(pc_in), .ack_o(ack_o), .vector_o(vector_o), .pop_addr(pop_addr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int m_byte(input bit sel);
        if (!sel) return {24'd0, 1'b0, m_flg[2:0], m_en[2:0], m_emi};
        return {24'd0, 3'b000, m_flg[3], 3'b000, m_en[3]};
    endfunction

    function automatic int pick(input bit [3:0] p);
        for (int i = 0; i < 4; i++) if (p[i]) return i;
        return -1;
    endfunction

    task automatic m_push(input int v);
        if (scnt == 6) begin
            for (int i = 0; i < 5; i++) stk[i] = stk[i + 1];
            stk[5] = v;
        end else begin
            stk[scnt] = v;
            scnt++;
        end
    endtask

    // one clock: predict, advance, compare, clear strobes
    task automatic step();
        bit [3:0] pend;
        bit       g;
        int       src;
        pend = m_flg & m_en & {4{m_emi}};
        g    = !m_ack && sample_stb && !(call_stb || ret_stb || reti_stb) &&
               (pend != 0) && (scnt < 6);
        src  = pick(pend);
        if (reg_wr) begin
            if (!reg_sel) begin
                m_emi = reg_wdata[0]; m_en[2:0] = reg_wdata[3:1]; m_flg[2:0] = reg_wdata[6:4];
            end else begin
                m_en[3] = reg_wdata[0]; m_flg[3] = reg_wdata[4];
            end
        end
        if (reti_stb) m_emi = 1'b1;
        if (g) begin m_emi = 1'b0; m_flg[src] = 1'b0; end
        if (m_prev && !ext_pin) m_flg[0] = 1'b1;
        if (tmr_evt) m_flg[1] = 1'b1;
        if (cnv_evt) m_flg[2] = 1'b1;
        if (ser_evt) m_flg[3] = 1'b1;
        if (call_stb) m_push(int'(pc_in));
        else if ((ret_stb || reti_stb) && scnt > 0) scnt--;
        if (g) m_push(int'(pc_in));
        m_ack  = g;
        m_vec  = (src + 1) * 4;
        m_prev = ext_pin;
        @(posedge clk); #1;
        chk("R1 ack", int'(ack_o), int'(m_ack));
        if (m_ack) chk("R1 vector", int'(vector_o), m_vec);
        chk("R9 read byte", int'(reg_rdata), m_byte(reg_sel));
        if (scnt > 0) chk("R8 top of stack", int'(pop_addr), stk[scnt - 1]);
        tmr_evt = 0; cnv_evt = 0; ser_evt = 0; reg_wr = 0;
        call_stb = 0; ret_stb = 0; reti_stb = 0; sample_stb = 0;
    endtask

    task automatic wr(input bit sel, input logic [7:0] d);
        reg_sel = sel; reg_wr = 1; reg_wdata = d; step();
    endtask

    task automatic rd_chk(input bit sel, input int exp, input string tag);
        reg_sel = sel; step(); chk(tag, int'(reg_rdata), exp);
    endtask

    task automatic samp(input logic [10:0] pc);
        sample_stb = 1; pc_in = pc; step();
    endtask

    task automatic call(input logic [10:0] pc);
        call_stb = 1; pc_in = pc; step();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_emi = 0; m_en = 0; m_flg = 0; scnt = 0; m_ack = 0; m_prev = 1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R10 reset state
        chk("R10 ack after reset", int'(ack_o), 0);
        rd_chk(0, 8'h00, "R10 byte0 reset");
        rd_chk(1, 8'h00, "R10 byte1 reset");

        // R2 external edge
        ext_pin = 0; step();
        rd_chk(0, 8'h10, "R2 falling edge sets flag");
        wr(0, 8'h00);
        step();
        rd_chk(0, 8'h00, "R2 held low does not set again");
        ext_pin = 1; step();
        rd_chk(0, 8'h00, "R2 rising edge does not set");

        // R3 flag persistence and software write
        tmr_evt = 1; step();
        repeat (3) step();
        rd_chk(0, 8'h20, "R3 timer flag held");
        ser_evt = 1; step();
        rd_chk(1, 8'h10, "R3 serial flag held");
        wr(0, 8'h00); wr(1, 8'h00);
        rd_chk(0, 8'h00, "R3 software clear byte0");
        rd_chk(1, 8'h00, "R3 software clear byte1");

        // R9 layout with all bits written
        wr(0, 8'hFF);
        rd_chk(0, 8'h7F, "R9 byte0 bit7 reads 0");
        wr(1, 8'hFF);
        rd_chk(1, 8'h11, "R9 byte1 unused bits read 0");

        // R1/R4/R5 priority chain
        samp(11'h123);
        chk("R1 external first", int'(vector_o), 11'h004);
        chk("R11 ack pushes pc", int'(pop_addr), 11'h123);
        rd_chk(0, 8'h6E, "R4 ext flag and master cleared");
        rd_chk(1, 8'h11, "R4 serial flag kept");
        samp(11'h124);
        chk("R4 nesting blocked", int'(ack_o), 0);
        reti_stb = 1; step();
        rd_chk(0, 8'h6F, "R5 reti sets master");
        samp(11'h130);
        chk("R1 timer second", int'(vector_o), 11'h008);
        ret_stb = 1; step();
        rd_chk(0, 8'h4E, "R5 plain return leaves master off");
        wr(0, 8'h4F);
        samp(11'h140);
        chk("R1 conversion third", int'(vector_o), 11'h00C);
        reti_stb = 1; step();
        samp(11'h150);
        chk("R1 serial last", int'(vector_o), 11'h010);
        rd_chk(1, 8'h01, "R4 serial flag cleared");
        reti_stb = 1; step();

        // R6 gating
        wr(0, 8'h11);
        samp(11'h160);
        chk("R6 source enable off", int'(ack_o), 0);
        wr(0, 8'h12);
        samp(11'h161);
        chk("R6 master enable off", int'(ack_o), 0);
        wr(0, 8'h00);

        // R7 stack full withholds
        for (int i = 0; i < 6; i++) call(11'h100 + 11'(i));
        wr(0, 8'h13);
        samp(11'h170);
        chk("R7 no ack while full", int'(ack_o), 0);
        rd_chk(0, 8'h13, "R7 request recorded");
        ret_stb = 1; step();
        samp(11'h171);
        chk("R7 ack after pop", int'(ack_o), 1);
        chk("R7 vector after pop", int'(vector_o), 11'h004);
        for (int i = 0; i < 6; i++) begin ret_stb = 1; step(); end
        wr(0, 8'h00);

        // R8 overflow drops oldest
        for (int i = 1; i <= 8; i++) call(11'h200 + 11'(i));
        for (int k = 0; k < 6; k++) begin
            chk("R8 lifo after overflow", int'(pop_addr), 11'h208 - k);
            ret_stb = 1; step();
        end

        // R12 pop on empty
        ret_stb = 1; step();
        reti_stb = 1; step();
        wr(0, 8'h00);
        for (int i = 1; i <= 6; i++) call(11'h300 + 11'(i));
        for (int k = 0; k < 6; k++) begin
            chk("R12 all six kept after empty pop", int'(pop_addr), 11'h306 - k);
            ret_stb = 1; step();
        end

        // R11 strobe defers acknowledge
        wr(0, 8'h13);
        sample_stb = 1; call_stb = 1; pc_in = 11'h055; step();
        chk("R11 call defers ack", int'(ack_o), 0);
        chk("R11 call pushed", int'(pop_addr), 11'h055);
        samp(11'h066);
        chk("R11 clean sample acks", int'(ack_o), 1);
        chk("R11 ack pushed pc", int'(pop_addr), 11'h066);
        samp(11'h067);
        chk("R11 sample during grant ignored", int'(ack_o), 0);
        reti_stb = 1; step();
        ret_stb = 1; step();
        wr(0, 8'h00); wr(1, 8'h00);

        // seeded random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            int r;
            if (($urandom % 100) < 10) ext_pin = ~ext_pin;
            tmr_evt = (($urandom % 100) < 5);
            cnv_evt = (($urandom % 100) < 5);
            ser_evt = (($urandom % 100) < 5);
            reg_sel = 1'($urandom % 2);
            reg_wr  = (($urandom % 100) < 8);
            reg_wdata = 8'($urandom);
            r = $urandom % 100;
            call_stb = (r < 5);
            ret_stb  = (r >= 5 && r < 8);
            reti_stb = (r >= 8 && r < 11) || (r == 99);
            if (r == 99) call_stb = 1;
            sample_stb = (($urandom % 100) < 35);
            pc_in = 11'($urandom);
            step();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule